// File: doc/BRIEF.md
# Serial Packet Receive Deframer

This block sits between a low-power radio receiver and a sensor node's controller. It owns the receiver's power state through a 2-bit control output. It keeps the receiver asleep for a fixed number of cycles, then wakes it and searches the incoming serial stream for an 8-bit start pattern. If no pattern arrives within a bounded search window, the receiver goes back to sleep. When the pattern is found, the next nine serial bits are captured, most significant first, as one record. The record holds a 3-bit address in its top bits and a 6-bit payload below it.

The record is presented as a 9-bit word qualified by a one-cycle valid strobe. The receiver is put back to sleep on the cycle after the strobe, and the sleep period starts again. One serial bit is sampled on each rising clock edge. Bit timing recovery, error correction and any network handling are done elsewhere.

Top module: `rx_deframer`

## Requirements
- R1: While `rst_ni` is low, `rx_ctrl_o` is 00, `rx_valid_o` is 0 and `rx_word_o` is 0. The reset acts asynchronously, so a reset in the middle of a capture drops the partial record.
- R2: `rx_ctrl_o` takes only two values: 00 for sleep and 11 for active. After reset is released, or after a record has been delivered, it stays 00 for exactly SLEEP_CYCLES (16) rising edges and then becomes 11.
- R3: While active and searching, capture starts only when the last 8 sampled bits, oldest first, equal 10101011 (the parameter PREAMBLE). The match is checked at every bit position, so noise bits before the pattern do no harm.
- R4: If no match occurs within HUNT_CYCLES (32) sampled bits of waking, `rx_ctrl_o` returns to 00 and a new sleep period begins. A near miss such as 10101010 starts no capture.
- R5: Serial input is ignored while `rx_ctrl_o` is 00. No pattern sent during sleep produces a record.
- R6: The nine bits that follow the pattern are captured first-bit-as-MSB into `rx_word_o`. Bits [8:6] hold the address and bits [5:0] hold the payload. For example, address 010 with payload 000111 gives 9'h087.
- R7: `rx_valid_o` is high for exactly one cycle, the cycle after the edge that samples the ninth field bit. `rx_word_o` carries the new record in that cycle.
- R8: `rx_ctrl_o` is 11 during the valid cycle and 00 on the cycle after it.
- R9: `rx_word_o` holds the last delivered record until the next valid strobe.
- R10: Field bits are taken as data even if they contain the start pattern. A field of 9'b101010111 is delivered as 9'h157 and does not restart the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one serial bit sampled per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_bit_i | input | 1 | Serial data from the receiver |
| rx_ctrl_o | output | 2 | Receiver power control: 00 sleep, 11 active |
| rx_word_o | output | 9 | Recovered record: address [8:6], payload [5:0] |
| rx_valid_o | output | 1 | One-cycle strobe qualifying rx_word_o |

## Verification
Clean frames carry the example record, all-ones, all-zeros and mixed fields. Together they show that bits are ordered correctly and that the address and payload sit in the right positions. A frame with noise bits before the pattern shows that the search slides across bit positions. A field that contains the pattern shows that the search is not restarted during capture. A pattern sent while asleep, and a near-miss pattern followed by silence, show that sleep gating works, that only an exact match starts a capture, and how long the search window lasts. A reset in the middle of a record shows that the partial record is dropped and that the sleep count restarts from the release of reset.

// File: rtl/rx_deframer_pkg.sv
package rx_deframer_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP,
    ST_HUNT,
    ST_CAPTURE,
    ST_DONE
  } rx_state_e;

  localparam logic [1:0] CTRL_SLEEP  = 2'b00;
  localparam logic [1:0] CTRL_ACTIVE = 2'b11;
endpackage

// File: rtl/rx_wake_timer.sv
module rx_wake_timer #(
  parameter int SLEEP_CYCLES = 16,
  parameter int HUNT_CYCLES  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic sleep_done_o,
  output logic hunt_done_o
);
  localparam int MAX_CYC = (SLEEP_CYCLES > HUNT_CYCLES) ? SLEEP_CYCLES : HUNT_CYCLES;
  localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign sleep_done_o = (cnt_q == CW'(SLEEP_CYCLES - 1));
  assign hunt_done_o  = (cnt_q == CW'(HUNT_CYCLES - 1));
endmodule

// File: rtl/rx_preamble_det.sv
module rx_preamble_det #(
  parameter int               PRE_W    = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'b1010_1011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic match_o
);
  // history of the previous PRE_W-1 bits plus a fill mask
  logic [PRE_W-2:0] hist_q;
  logic [PRE_W-2:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (!en_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= {hist_q[PRE_W-3:0], bit_i};
      fill_q <= {fill_q[PRE_W-3:0], 1'b1};
    end
  end

  assign match_o = en_i && fill_q[PRE_W-2] && ({hist_q, bit_i} == PREAMBLE);
endmodule

// File: rtl/rx_field_shift.sv
module rx_field_shift #(
  parameter int FIELD_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               bit_i,
  output logic               last_o,
  output logic [FIELD_W-1:0] field_o
);
  localparam int CW = $clog2(FIELD_W);

  logic [FIELD_W-2:0] sr_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= {sr_q[FIELD_W-3:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o  = en_i && (cnt_q == CW'(FIELD_W - 1));
  assign field_o = {sr_q, bit_i};
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rx_deframer_pkg::*;
#(
  parameter int                 SLEEP_CYCLES = 16,
  parameter int                 HUNT_CYCLES  = 32,
  parameter int                 PRE_W        = 8,
  parameter logic [PRE_W-1:0]   PREAMBLE     = 8'b1010_1011,
  parameter int                 ADDR_W       = 3,
  parameter int                 DATA_W       = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_bit_i,
  output logic [1:0]               rx_ctrl_o,
  output logic [ADDR_W+DATA_W-1:0] rx_word_o,
  output logic                     rx_valid_o
);
  localparam int WORD_W = ADDR_W + DATA_W;

  rx_state_e          state_q, state_d;
  logic               tmr_clr, tmr_en, sleep_done, hunt_done;
  logic               pre_match, fld_last;
  logic [WORD_W-1:0]  fld_word, word_q;

  rx_wake_timer #(
    .SLEEP_CYCLES(SLEEP_CYCLES),
    .HUNT_CYCLES (HUNT_CYCLES)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (tmr_clr),
    .en_i        (tmr_en),
    .sleep_done_o(sleep_done),
    .hunt_done_o (hunt_done)
  );

  rx_preamble_det #(
    .PRE_W   (PRE_W),
    .PREAMBLE(PREAMBLE)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_HUNT),
    .bit_i  (rx_bit_i),
    .match_o(pre_match)
  );

  rx_field_shift #(
    .FIELD_W(WORD_W)
  ) u_fld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_CAPTURE),
    .bit_i  (rx_bit_i),
    .last_o (fld_last),
    .field_o(fld_word)
  );

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    unique case (state_q)
      ST_SLEEP: begin
        tmr_en = 1'b1;
        if (sleep_done) begin
          state_d = ST_HUNT;
          tmr_clr = 1'b1;
        end
      end
      ST_HUNT: begin
        tmr_en = 1'b1;
        if (pre_match) begin
          state_d = ST_CAPTURE;
          tmr_clr = 1'b1;
        end else if (hunt_done) begin
          state_d = ST_SLEEP;
          tmr_clr = 1'b1;
        end
      end
      ST_CAPTURE: begin
        if (fld_last) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_SLEEP;
        tmr_clr = 1'b1;
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CAPTURE && fld_last) word_q <= fld_word;
    end
  end

  assign rx_ctrl_o  = (state_q == ST_SLEEP) ? CTRL_SLEEP : CTRL_ACTIVE;
  assign rx_valid_o = (state_q == ST_DONE);
  assign rx_word_o  = word_q;
endmodule

// File: rtl/rx_deframer_chk.sv
module rx_deframer_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               rx_ctrl_o,
  input logic [ADDR_W+DATA_W-1:0] rx_word_o,
  input logic                     rx_valid_o
);
  p_ctrl_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_o == 2'b00) || (rx_ctrl_o == 2'b11));

  p_no_wake_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_o == 2'b00) |=> !rx_valid_o);

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_valid_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_ctrl_o == 2'b11));

  p_sleep_after_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> (rx_ctrl_o == 2'b00));

  p_word_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_word_o));
endmodule

bind rx_deframer rx_deframer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_ctrl_o (rx_ctrl_o),
  .rx_word_o (rx_word_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/rx_deframer_tb.sv
`timescale 1ns/1ps
module rx_deframer_tb;
  localparam int SLEEP_CYCLES = 16;
  localparam int HUNT_CYCLES  = 32;
  localparam logic [7:0] PRE  = 8'b1010_1011;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_bit_i = 1'b0;
  logic [1:0] rx_ctrl_o;
  logic [8:0] rx_word_o;
  logic       rx_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rx_deframer u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rx_bit_i  (rx_bit_i),
    .rx_ctrl_o (rx_ctrl_o),
    .rx_word_o (rx_word_o),
    .rx_valid_o(rx_valid_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one bit, let one edge sample it, return at the following negedge
  task automatic drive_bit(input logic b);
    rx_bit_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) begin
      drive_bit(v[i]);
      if (i != 0) check(rx_valid_o == 1'b0, tag, rx_valid_o, 0);
    end
  endtask

  task automatic wait_wake(input string tag);
    int n = 0;
    while (rx_ctrl_o != 2'b11 && n < 200) begin
      drive_bit(1'b0);
      n++;
    end
    check(n == SLEEP_CYCLES, tag, n, SLEEP_CYCLES);
  endtask

  task automatic send_frame(input logic [15:0] junk, input int njunk,
                            input logic [8:0] word, input string tag);
    if (njunk > 0) send_bits(junk, njunk, "R3 junk");
    send_bits({8'h00, PRE}, 8, "R3 preamble");
    check(rx_valid_o == 1'b0, "R3 no early valid", rx_valid_o, 0);
    send_bits({7'h00, word}, 9, tag);
    check(rx_valid_o == 1'b1, {tag, " R7 valid"}, rx_valid_o, 1);
    check(rx_word_o == word, {tag, " R6 word"}, rx_word_o, word);
    check(rx_ctrl_o == 2'b11, "R8 active during valid", rx_ctrl_o, 3);
    drive_bit(1'b0);
    check(rx_valid_o == 1'b0, "R7 one-cycle strobe", rx_valid_o, 0);
    check(rx_ctrl_o == 2'b00, "R8 sleep after valid", rx_ctrl_o, 0);
    wait_wake("R2 sleep length after frame");
    check(rx_word_o == word, "R9 word held", rx_word_o, word);
  endtask

  task automatic t_reset();
    check(rx_ctrl_o == 2'b00, "R1 reset ctrl", rx_ctrl_o, 0);
    check(rx_valid_o == 1'b0, "R1 reset valid", rx_valid_o, 0);
    check(rx_word_o == 9'h0, "R1 reset word", rx_word_o, 0);
  endtask

  task automatic t_sleep_ignores();
    logic [16:0] pat = {PRE, 9'h087};
    for (int i = 0; i < SLEEP_CYCLES - 1; i++) begin
      drive_bit(pat[16 - i]);
      check(rx_valid_o == 1'b0, "R5 no record while asleep", rx_valid_o, 0);
    end
    check(rx_ctrl_o == 2'b00, "R2 still asleep", rx_ctrl_o, 0);
    drive_bit(1'b0);
    check(rx_ctrl_o == 2'b11, "R2 wake after sleep period", rx_ctrl_o, 3);
  endtask

  task automatic t_near_miss_timeout();
    logic [7:0] miss = 8'b1010_1010;
    for (int i = 1; i <= HUNT_CYCLES; i++) begin
      drive_bit(i <= 8 ? miss[8 - i] : 1'b0);
      check(rx_valid_o == 1'b0, "R4 near miss no record", rx_valid_o, 0);
      if (i == HUNT_CYCLES - 1)
        check(rx_ctrl_o == 2'b11, "R4 still hunting", rx_ctrl_o, 3);
    end
    check(rx_ctrl_o == 2'b00, "R4 hunt timeout sleeps", rx_ctrl_o, 0);
    wait_wake("R2 sleep length after timeout");
  endtask

  task automatic t_reset_mid_capture();
    send_bits({8'h00, PRE}, 8, "R11 preamble");
    send_bits(16'h000B, 4, "R1 partial");
    rst_ni = 1'b0;
    #1;
    check(rx_ctrl_o == 2'b00, "R1 reset mid-capture ctrl", rx_ctrl_o, 0);
    check(rx_valid_o == 1'b0, "R1 reset mid-capture valid", rx_valid_o, 0);
    check(rx_word_o == 9'h0, "R1 reset mid-capture word", rx_word_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    wait_wake("R2 sleep length after reset");
    send_frame(16'h0, 0, 9'h087, "R1 frame after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_sleep_ignores();
    send_frame(16'h0, 0, 9'b010_000111, "R6 example");
    send_frame(16'h0, 0, 9'h178, "R6 mixed");
    send_frame(16'b0110, 4, 9'h1FF, "R3 junk lead ones");
    send_frame(16'h0, 0, 9'h000, "R6 zeros");
    send_frame(16'h0, 0, 9'b1_0101_0111, "R10 pattern in field");
    t_near_miss_timeout();
    t_reset_mid_capture();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule